// File: doc/BRIEF.md
# PCI Target Command and Burst Address Tracker

This block sits on the target side of a 32-bit PCI-style bus. When a transaction starts it latches the command/byte-enable nibble and the address. It maps the command onto a small set of internal access types and decides whether the device claims the transaction. While a claimed burst runs, it produces the current address for each data phase. Address-range matching, data movement, parity generation and the electrical handshake are handled by neighbouring logic.

Several memory command variants fold into a plain memory read or a plain memory write. Configuration accesses are confined to a 256-byte space. Memory bursts follow either linear order or cache-line wrap order, chosen by the two low address bits. A reserved order encoding is still claimed, runs as a linear burst, and raises a sticky error flag. A dual-address cycle, reserved commands and all non-memory, non-configuration commands are not claimed; they raise a skip indication instead.

Top module: `pci_tgt_cmd_tracker`

## Requirements
- R1: While `rst_n` is low, at each clock `claim_o`, `skip_o`, `wrap_mode_o` and `order_err_o` go to 0, `acc_type_o` goes to 0 (none) and `cur_addr_o` goes to 0.
- R2: A capture happens on a clock where `frame_i` and `bus_idle_i` are both high. The command decodes as follows, and the access is claimed: 0110, 1100 and 1110 give `acc_type_o` = 1 (memory read); 0111 and 1111 give `acc_type_o` = 2 (memory write).
- R3: Command 1010 gives `acc_type_o` = 3 and command 1011 gives `acc_type_o` = 4. Both are claimed, and `cur_addr_o` holds only `ad_i[7:0]`, with bits 31:8 zero.
- R4: Commands 1101 (dual address), 1001 and every other command outside R2/R3 are not claimed: `claim_o` = 0, `skip_o` = 1, `acc_type_o` = 0. `dphase_done_i` does not change `cur_addr_o` during such a transaction.
- R5: In a linear memory burst (`ad_i[1:0]` = 00 at capture), each clock with `dphase_done_i` high and `bus_idle_i` low adds 4 to `cur_addr_o`, with carry through bit 31. `cur_addr_o` holds while `dphase_done_i` is low.
- R6: Commands 0110, 0111 and 1100 with `ad_i[1:0]` = 10 run in wrap order, and `wrap_mode_o` = 1. Each data phase increments only `cur_addr_o[4:2]` modulo 8, so the address stays inside its aligned 32-byte line.
- R7: Commands 1110 and 1111 with `ad_i[1:0]` = 10 run in linear order, and `wrap_mode_o` = 0.
- R8: A memory command with `ad_i[1:0]` = 01 or 11 is claimed and runs in linear order. It sets `order_err_o`, which stays set until a clear or reset.
- R9: A clock with `err_clr_i` high clears `order_err_o`, except when a reserved-order memory capture happens on the same clock; then the flag ends up set.
- R10: During a memory burst, `cur_addr_o[1:0]` keeps the two low bits captured from `ad_i`.
- R11: In a configuration access, each data phase adds 4 to `cur_addr_o` modulo 256.
- R12: A clock with `frame_i` low and `bus_idle_i` high ends the transaction. `claim_o`, `skip_o` and `wrap_mode_o` drop to 0, `acc_type_o` goes to 0, and a `dphase_done_i` on that clock is ignored. `frame_i` high with `bus_idle_i` low causes no new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_i | input | 1 | Frame asserted (active high) |
| bus_idle_i | input | 1 | Bus idle indication from the handshake logic |
| cbe_i | input | 4 | Command / byte-enable nibble |
| ad_i | input | 32 | Multiplexed address/data bus |
| dphase_done_i | input | 1 | Data phase completed this clock |
| err_clr_i | input | 1 | Clear pulse for the order-error flag |
| acc_type_o | output | 3 | Access type: 0 none, 1 mem read, 2 mem write, 3 cfg read, 4 cfg write |
| claim_o | output | 1 | Device claims the current transaction |
| skip_o | output | 1 | Current transaction is not claimed |
| cur_addr_o | output | 32 | Address of the current data phase |
| wrap_mode_o | output | 1 | Burst runs in cache-line wrap order |
| order_err_o | output | 1 | Sticky reserved-burst-order error |

## Verification
The sticky order-error flag can receive its set and its clear on the same clock. This happens when `err_clr_i` pulses exactly as a memory command with a reserved low-address encoding is captured. The bench drives that case on purpose, and it also drives a clear pulse alone. The reference model expects the set to win, so the flag must read 1 after the shared clock and 0 after the lone clear. A second coincidence is a data-phase strobe on the clock that ends the transaction; it is judged by checking that `cur_addr_o` stays unchanged.

// File: rtl/pci_tgt_pkg.sv
// Package: shared types for the PCI target command tracker.
// Holds the access-type codes seen at the top-level port and the
// address-advance modes used between the decoder and the counter.
package pci_tgt_pkg;

    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,
        ACC_MEM_RD = 3'd1,
        ACC_MEM_WR = 3'd2,
        ACC_CFG_RD = 3'd3,
        ACC_CFG_WR = 3'd4
    } acc_type_e;

    typedef enum logic [1:0] {
        ADV_HOLD = 2'd0,
        ADV_LIN  = 2'd1,
        ADV_WRAP = 2'd2,
        ADV_CFG  = 2'd3
    } adv_mode_e;

    // Command nibble values the decoder recognises.
    localparam logic [3:0] CMD_MEM_RD   = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR   = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD   = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR   = 4'b1011;
    localparam logic [3:0] CMD_MEM_RDM  = 4'b1100;
    localparam logic [3:0] CMD_MEM_RDL  = 4'b1110;
    localparam logic [3:0] CMD_MEM_WRI  = 4'b1111;

    // Burst order encodings of the two low address bits.
    localparam logic [1:0] ORD_LINEAR = 2'b00;
    localparam logic [1:0] ORD_WRAP   = 2'b10;

endpackage

// File: rtl/pci_tgt_cmd_decode.sv
// Module: pci_tgt_cmd_decode
// Purely combinational. Maps the command nibble and the two low address
// bits onto an access type, a claim decision, an address-advance mode,
// a wrap indication and a reserved-order indication.
// Assumes: inputs are the values present during the address phase.
module pci_tgt_cmd_decode
    import pci_tgt_pkg::*;
(
    input  logic [3:0] cbe_i,
    input  logic [1:0] ad_lo_i,
    output acc_type_e  acc_o,
    output logic       claim_o,
    output adv_mode_e  mode_o,
    output logic       wrap_o,
    output logic       bad_order_o
);

    logic is_mem;
    logic wrap_capable;

    // Classify the command nibble into an access type.
    always_comb begin
        wrap_capable = 1'b0;
        case (cbe_i)
            CMD_MEM_RD:  begin acc_o = ACC_MEM_RD; wrap_capable = 1'b1; end
            CMD_MEM_RDM: begin acc_o = ACC_MEM_RD; wrap_capable = 1'b1; end
            CMD_MEM_RDL: acc_o = ACC_MEM_RD;
            CMD_MEM_WR:  begin acc_o = ACC_MEM_WR; wrap_capable = 1'b1; end
            CMD_MEM_WRI: acc_o = ACC_MEM_WR;
            CMD_CFG_RD:  acc_o = ACC_CFG_RD;
            CMD_CFG_WR:  acc_o = ACC_CFG_WR;
            default:     acc_o = ACC_NONE;
        endcase
    end

    // Derive claim, burst order and advance mode from the access type.
    always_comb begin
        is_mem      = (acc_o == ACC_MEM_RD) || (acc_o == ACC_MEM_WR);
        claim_o     = (acc_o != ACC_NONE);
        wrap_o      = is_mem && wrap_capable && (ad_lo_i == ORD_WRAP);
        bad_order_o = is_mem && ad_lo_i[0];
        if (is_mem)
            mode_o = wrap_o ? ADV_WRAP : ADV_LIN;
        else if (claim_o)
            mode_o = ADV_CFG;
        else
            mode_o = ADV_HOLD;
    end

endmodule

// File: rtl/pci_tgt_addr_ctr.sv
// Module: pci_tgt_addr_ctr
// Holds the running byte address of a burst. On load it captures the bus
// address (masked to the configuration space for configuration accesses).
// On step it adds one word inside a field chosen by the advance mode:
// the whole word address (linear), the line offset (wrap) or the
// configuration offset. Bits outside the field and bits [1:0] are kept.
// Assumes: load has priority over step.
module pci_tgt_addr_ctr
    import pci_tgt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int CFG_BYTES  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              load_cfg_i,
    input  logic [ADDR_W-1:0] ad_i,
    input  logic              step_i,
    input  adv_mode_e         mode_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int WRAP_W = $clog2(LINE_WORDS);
    localparam int CFG_W  = $clog2(CFG_BYTES);
    localparam logic [ADDR_W-1:0] ONE       = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] STEP      = ONE << 2;
    localparam logic [ADDR_W-1:0] LIN_MASK  = ~(STEP - ONE);
    localparam logic [ADDR_W-1:0] WRAP_MASK = (ONE << (WRAP_W + 2)) - STEP;
    localparam logic [ADDR_W-1:0] CFG_KEEP  = (ONE << CFG_W) - ONE;
    localparam logic [ADDR_W-1:0] CFG_MASK  = (ONE << CFG_W) - STEP;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] field_mask;
    logic [ADDR_W-1:0] addr_next;

    // Pick the bits that take part in the increment for this mode.
    always_comb begin
        case (mode_i)
            ADV_LIN:  field_mask = LIN_MASK;
            ADV_WRAP: field_mask = WRAP_MASK;
            ADV_CFG:  field_mask = CFG_MASK;
            default:  field_mask = '0;
        endcase
        addr_next = (addr_q & ~field_mask) | ((addr_q + STEP) & field_mask);
    end

    // Address register: reset, capture or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load_i)
            addr_q <= load_cfg_i ? (ad_i & CFG_KEEP) : ad_i;
        else if (step_i)
            addr_q <= addr_next;
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/pci_tgt_err_flag.sv
// Module: pci_tgt_err_flag
// Sticky flag. A set pulse makes it 1, a clear pulse makes it 0,
// and a set on the same clock as a clear wins.
// Assumes: set and clear are single-clock qualified strobes.
module pci_tgt_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Flag register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/pci_tgt_cmd_tracker.sv
// Module: pci_tgt_cmd_tracker (top)
// Target-side tracker for a 32-bit PCI-style bus. Captures the command
// and address when frame is seen on an idle bus, then holds the access
// type and claim decision until frame drops on an idle bus. For claimed
// accesses the address advances on every completed data phase.
// Assumes: bus_idle_i is high only between transactions and on the first
// clock of a new frame; dphase_done_i comes from the bus handshake logic.
module pci_tgt_cmd_tracker
    import pci_tgt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int CFG_BYTES  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              bus_idle_i,
    input  logic [3:0]        cbe_i,
    input  logic [ADDR_W-1:0] ad_i,
    input  logic              dphase_done_i,
    input  logic              err_clr_i,
    output logic [2:0]        acc_type_o,
    output logic              claim_o,
    output logic              skip_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              wrap_mode_o,
    output logic              order_err_o
);

    acc_type_e dec_acc;
    logic      dec_claim;
    adv_mode_e dec_mode;
    logic      dec_wrap;
    logic      dec_bad;

    acc_type_e acc_q;
    logic      claim_q;
    logic      skip_q;
    adv_mode_e mode_q;
    logic      wrap_q;

    logic start;
    logic finish;
    logic advance;

    pci_tgt_cmd_decode u_dec (
        .cbe_i       (cbe_i),
        .ad_lo_i     (ad_i[1:0]),
        .acc_o       (dec_acc),
        .claim_o     (dec_claim),
        .mode_o      (dec_mode),
        .wrap_o      (dec_wrap),
        .bad_order_o (dec_bad)
    );

    // Transaction boundaries and data-phase qualification.
    always_comb begin
        start   = frame_i && bus_idle_i;
        finish  = !frame_i && bus_idle_i;
        advance = claim_q && dphase_done_i && !bus_idle_i;
    end

    // Per-transaction state: captured at start, cleared at finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= ACC_NONE;
            claim_q <= 1'b0;
            skip_q  <= 1'b0;
            mode_q  <= ADV_HOLD;
            wrap_q  <= 1'b0;
        end else if (start) begin
            acc_q   <= dec_acc;
            claim_q <= dec_claim;
            skip_q  <= !dec_claim;
            mode_q  <= dec_mode;
            wrap_q  <= dec_wrap;
        end else if (finish) begin
            acc_q   <= ACC_NONE;
            claim_q <= 1'b0;
            skip_q  <= 1'b0;
            mode_q  <= ADV_HOLD;
            wrap_q  <= 1'b0;
        end
    end

    pci_tgt_addr_ctr #(
        .ADDR_W     (ADDR_W),
        .LINE_WORDS (LINE_WORDS),
        .CFG_BYTES  (CFG_BYTES)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start),
        .load_cfg_i (dec_mode == ADV_CFG),
        .ad_i       (ad_i),
        .step_i     (advance),
        .mode_i     (mode_q),
        .addr_o     (cur_addr_o)
    );

    pci_tgt_err_flag u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (start && dec_bad),
        .clr_i  (err_clr_i),
        .flag_o (order_err_o)
    );

    assign acc_type_o  = acc_q;
    assign claim_o     = claim_q;
    assign skip_o      = skip_q;
    assign wrap_mode_o = wrap_q;

endmodule

// File: rtl/pci_tgt_cmd_tracker_chk.sv
// Module: pci_tgt_cmd_tracker_chk
// Property checker attached to the tracker top through bind. It watches
// only top-level ports.
module pci_tgt_cmd_tracker_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_i,
    input logic              bus_idle_i,
    input logic [3:0]        cbe_i,
    input logic [1:0]        ad_lo,
    input logic              dphase_done_i,
    input logic              err_clr_i,
    input logic [2:0]        acc_type_o,
    input logic              claim_o,
    input logic              skip_o,
    input logic [ADDR_W-1:0] cur_addr_o,
    input logic              wrap_mode_o,
    input logic              order_err_o
);

    localparam int LINE_LSB = $clog2(LINE_WORDS) + 2;

    logic mem_cmd;
    assign mem_cmd = (cbe_i == 4'b0110) || (cbe_i == 4'b0111) ||
                     (cbe_i == 4'b1100) || (cbe_i == 4'b1110) ||
                     (cbe_i == 4'b1111);

    // R4: dual-address cycle is never claimed
    a_r4_dac_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && bus_idle_i && cbe_i == 4'b1101) |=> (!claim_o && skip_o));

    // R5: address holds without a completed data phase
    a_r5_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!dphase_done_i && !bus_idle_i) |=> $stable(cur_addr_o));

    // R5: linear memory burst steps by one word
    a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o && !wrap_mode_o && (acc_type_o == 3'd1 || acc_type_o == 3'd2)
         && dphase_done_i && !bus_idle_i)
        |=> (cur_addr_o == $past(cur_addr_o) + 4));

    // R6: wrap bursts never leave the aligned line
    a_r6_line_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_mode_o && dphase_done_i && !bus_idle_i)
        |=> (cur_addr_o[ADDR_W-1:LINE_LSB] == $past(cur_addr_o[ADDR_W-1:LINE_LSB])));

    // R8: order error stays set until cleared
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (order_err_o && !err_clr_i) |=> order_err_o);

    // R9: reserved-order capture sets the flag even under a clear pulse
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && bus_idle_i && mem_cmd && ad_lo[0]) |=> (order_err_o && claim_o));

    // R12: claim and skip are never both shown
    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(claim_o && skip_o));

endmodule

bind pci_tgt_cmd_tracker pci_tgt_cmd_tracker_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_WORDS (LINE_WORDS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_i       (frame_i),
    .bus_idle_i    (bus_idle_i),
    .cbe_i         (cbe_i),
    .ad_lo         (ad_i[1:0]),
    .dphase_done_i (dphase_done_i),
    .err_clr_i     (err_clr_i),
    .acc_type_o    (acc_type_o),
    .claim_o       (claim_o),
    .skip_o        (skip_o),
    .cur_addr_o    (cur_addr_o),
    .wrap_mode_o   (wrap_mode_o),
    .order_err_o   (order_err_o)
);

// File: tb/pci_tgt_cmd_tracker_test.sv
`timescale 1ns/1ps
// Scoreboard bench: tick() advances a reference model written from the
// requirements and queues the expected outputs; the monitor pops one item
// per clock just after the edge and compares it with the ports.
module pci_tgt_cmd_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame = 1'b0;
    logic        idle = 1'b1;
    logic [3:0]  cbe = 4'h0;
    logic [31:0] ad = 32'h0;
    logic        done = 1'b0;
    logic        clr = 1'b0;

    logic [2:0]  acc_type;
    logic        claim, skip, wrap_mode, order_err;
    logic [31:0] cur_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pci_tgt_cmd_tracker uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_i       (frame),
        .bus_idle_i    (idle),
        .cbe_i         (cbe),
        .ad_i          (ad),
        .dphase_done_i (done),
        .err_clr_i     (clr),
        .acc_type_o    (acc_type),
        .claim_o       (claim),
        .skip_o        (skip),
        .cur_addr_o    (cur_addr),
        .wrap_mode_o   (wrap_mode),
        .order_err_o   (order_err)
    );

    typedef struct {
        logic [2:0]  acc;
        logic        claim;
        logic        skip;
        logic        wrap;
        logic        err;
        logic [31:0] addr;
        string       req;
    } exp_t;

    exp_t q[$];

    // Reference model state; kind: 0 none, 1 linear, 2 wrap, 3 config
    logic [2:0]  m_acc = 0;
    logic        m_claim = 0, m_skip = 0, m_wrap = 0, m_err = 0;
    logic [31:0] m_addr = 0;
    int          m_kind = 0;

    task automatic model_step();
        bit setf;
        setf = 1'b0;
        if (!rst_n) begin
            m_acc = 0; m_claim = 0; m_skip = 0; m_wrap = 0; m_err = 0;
            m_addr = 0; m_kind = 0;
        end else if (frame && idle) begin
            case (cbe)
                4'b0110, 4'b1100, 4'b1110: m_acc = 3'd1;
                4'b0111, 4'b1111:          m_acc = 3'd2;
                4'b1010:                   m_acc = 3'd3;
                4'b1011:                   m_acc = 3'd4;
                default:                   m_acc = 3'd0;
            endcase
            m_claim = (m_acc != 0);
            m_skip  = !m_claim;
            m_wrap  = 1'b0;
            if (m_acc == 3'd1 || m_acc == 3'd2) begin
                m_addr = ad;
                m_wrap = (ad[1:0] == 2'b10) && (cbe != 4'b1110) && (cbe != 4'b1111);
                m_kind = m_wrap ? 2 : 1;
                setf   = (ad[1:0] == 2'b01) || (ad[1:0] == 2'b11);
            end else if (m_claim) begin
                m_addr = {24'h0, ad[7:0]};
                m_kind = 3;
            end else begin
                m_addr = ad;
                m_kind = 0;
            end
            if (setf) m_err = 1'b1;
            else if (clr) m_err = 1'b0;
        end else begin
            if (clr) m_err = 1'b0;
            if (!frame && idle) begin
                m_acc = 0; m_claim = 0; m_skip = 0; m_wrap = 0; m_kind = 0;
            end else if (done && m_claim) begin
                case (m_kind)
                    1: m_addr = m_addr + 32'd4;
                    2: m_addr = {m_addr[31:5], m_addr[4:2] + 3'd1, m_addr[1:0]};
                    3: m_addr = {24'h0, m_addr[7:2] + 6'd1, m_addr[1:0]};
                    default: ;
                endcase
            end
        end
    endtask

    task automatic tick(input string req);
        exp_t e;
        model_step();
        e.acc = m_acc; e.claim = m_claim; e.skip = m_skip; e.wrap = m_wrap;
        e.err = m_err; e.addr = m_addr; e.req = req;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare one queued expectation per clock, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_tests++;
            if ({acc_type, claim, skip, wrap_mode, order_err, cur_addr} !==
                {e.acc, e.claim, e.skip, e.wrap, e.err, e.addr}) begin
                n_fail++;
                $display("FAIL %s: acc=%0d claim=%0b skip=%0b wrap=%0b err=%0b addr=%h expected acc=%0d claim=%0b skip=%0b wrap=%0b err=%0b addr=%h",
                         e.req, acc_type, claim, skip, wrap_mode, order_err, cur_addr,
                         e.acc, e.claim, e.skip, e.wrap, e.err, e.addr);
            end
        end
    end

    // One transaction: capture, hold clock, n alternating data phases, end.
    task automatic txn(input logic [3:0] c, input logic [31:0] a, input int n,
                       input string req);
        frame = 1; idle = 1; cbe = c; ad = a; done = 0;
        tick(req);
        idle = 0; cbe = 4'b1101; ad = 32'hDEAD_BEEF;   // R12: no capture mid-burst
        tick(req);
        for (int i = 0; i < n; i++) begin
            done = 1; tick(req);
            done = 0; tick(req);
        end
        frame = 0; idle = 1; done = 1;                 // R12: strobe on end ignored
        tick("R12");
        done = 0;
        tick("R12");
    endtask

    initial begin
        @(negedge clk);
        rst_n = 0; tick("R1"); tick("R1");
        rst_n = 1; tick("R1");

        txn(4'b0110, 32'h1000_0000, 3, "R2 R5 linear read");
        txn(4'b0111, 32'hFFFF_FFF8, 3, "R5 carry wrap of 32-bit address");
        txn(4'b0111, 32'h2000_001A, 4, "R6 R10 wrap write");
        txn(4'b1100, 32'h3000_0006, 3, "R2 R6 read multiple wrap");
        txn(4'b1110, 32'h4000_001E, 2, "R2 R7 read line linear");
        txn(4'b1111, 32'h5000_001A, 2, "R7 write-invalidate linear");
        txn(4'b1010, 32'hABCD_12F8, 3, "R3 R11 cfg read");
        txn(4'b1011, 32'h0000_0044, 1, "R3 cfg write");
        txn(4'b1101, 32'h6000_0000, 2, "R4 dual address");
        txn(4'b1001, 32'h7000_0000, 1, "R4 reserved cmd");
        txn(4'b0010, 32'h0000_0300, 1, "R4 io read");

        txn(4'b0110, 32'h8000_0011, 2, "R8 R10 reserved order 01");
        clr = 0; tick("R8 sticky");
        clr = 1; tick("R9 clear alone");
        clr = 0; tick("R9");
        txn(4'b0111, 32'h9000_0003, 1, "R8 reserved order 11");
        // R9: clear on the same clock as a reserved-order capture
        frame = 1; idle = 1; cbe = 4'b0110; ad = 32'hA000_0001; clr = 1;
        tick("R9 set wins");
        clr = 0; idle = 0; tick("R9");
        frame = 0; idle = 1; tick("R12");
        clr = 1; tick("R9 clear after");
        clr = 0; tick("R9");

        // back-to-back capture: new frame on an idle bus replaces the old one
        frame = 1; idle = 1; cbe = 4'b1101; ad = 32'h0; tick("R4");
        frame = 1; idle = 1; cbe = 4'b0110; ad = 32'hB000_0000; tick("R2");
        idle = 0; done = 1; tick("R5");
        done = 0; frame = 0; idle = 1; tick("R12");

        rst_n = 0; tick("R1 mid-run reset");
        rst_n = 1; tick("R1");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule